// File: doc/BRIEF.md
# Wake-up Exit Delay Sequencer

This block decides when a processor core may run again after it leaves a sleep or idle state. On a wake pulse it captures the selected clock-source mode and whether the primary oscillator kept running. It then starts a fixed CPU preparation count and, in parallel, the oscillator-side wait that mode needs. That wait is a start-up count of oscillator edges for crystal modes, followed by a PLL lock count when the PLL is in use. For the low-frequency internal RC source it is a stabilization count instead. Two outputs result: a CPU-run enable and a clock-ready status bit.

The preparation count always applies. It overlaps the oscillator-side wait instead of following it, so the exit time is the longer of the two plus one cycle. On the low-frequency RC source the core resumes as soon as preparation ends, while the ready bit waits for stabilization. All delay lengths are parameters. All counting except oscillator start-up runs on the always-on timebase clock `clk`. Oscillator start-up counts `osc_pulse` strobes, one per oscillator edge, already brought into the `clk` domain. All pins are plain control and status levels or single-cycle strobes; there is no data stream and no back-pressure.

Top module: `wake_exit_seq`

## Requirements
- R1: After reset `cpu_run` is 1 and `clk_ready` is 1.
- R2: A `sleep_enter` strobe while running and not sequencing drops `cpu_run` on the next edge. It also clears `clk_ready` if `pri_running` is 0 and leaves it unchanged if `pri_running` is 1.
- R3: Counting the edge that samples an accepted `wake` as edge 0, `cpu_run` is never 1 before edge PREP_CYC+1, whatever the mode.
- R4: If `pri_running` is 1 at wake, no oscillator wait is applied: `cpu_run` rises at edge PREP_CYC+1 and `clk_ready` stays 1.
- R5: Mode 2 (external clock, `clk_mode`=2'b10) with `pri_running`=0: `cpu_run` rises at edge PREP_CYC+1 and `clk_ready` rises at edge 1.
- R6: Mode 0 (crystal, `clk_mode`=2'b00) with `pri_running`=0: let E be the edge sampling the OST_CYC-th `osc_pulse` after wake. `clk_ready` rises at E+1 and `cpu_run` at max(E, PREP_CYC)+1.
- R7: Mode 1 (crystal with PLL, `clk_mode`=2'b01) with `pri_running`=0: the lock count of PLL_CYC `clk` edges starts after the start-up count. `clk_ready` rises at E+PLL_CYC+1 and `cpu_run` at max(E+PLL_CYC, PREP_CYC)+1.
- R8: Mode 3 (low-frequency internal RC, `clk_mode`=2'b11) with `pri_running`=0: `cpu_run` rises at edge PREP_CYC+1 without waiting for stabilization, and `clk_ready` rises at edge STAB_CYC+1.
- R9: A `wake` strobe that arrives while a sequence is running is ignored and does not move either output's rise time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on timebase clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_mode | input | 2 | Clock-source mode, captured at wake |
| pri_running | input | 1 | Primary oscillator kept running while stopped |
| osc_pulse | input | 1 | One strobe per oscillator edge, in the `clk` domain |
| sleep_enter | input | 1 | Strobe: core enters sleep or idle |
| wake | input | 1 | Strobe: wake event |
| cpu_run | output | 1 | Instruction execution enable |
| clk_ready | output | 1 | Primary clock start-up complete |

## Verification
The bench sweeps all four modes, both values of `pri_running`, and oscillator strobe spacings of one, two and three clocks. With small parameters, the start-up end sometimes comes before preparation ends and sometimes after it. This separates an overlapped preparation count from one run in series, and a count of oscillator strobes from a count of clock edges. The PLL case shows that lock time is added after start-up, and the RC case shows that run and ready are decoupled. A second wake injected mid-sequence must leave both rise times unchanged.

// File: rtl/wake_exit_pkg.sv
package wake_exit_pkg;
  typedef enum logic [1:0] {
    MODE_XTAL     = 2'b00,
    MODE_XTAL_PLL = 2'b01,
    MODE_EXT      = 2'b10,
    MODE_LFRC     = 2'b11
  } clk_mode_e;

  typedef enum logic [2:0] {
    ST_DONE = 3'd0,
    ST_OST  = 3'd1,
    ST_PLL  = 3'd2,
    ST_STAB = 3'd3
  } osc_stage_e;
endpackage

// File: rtl/prep_timer.sv
module prep_timer #(
  parameter int unsigned PREP_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic zero
);
  localparam int unsigned PW = $clog2(PREP_CYC + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= PW'(PREP_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R9
  prep_no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/osc_stage_ctrl.sv
module osc_stage_ctrl
  import wake_exit_pkg::*;
#(
  parameter int unsigned OST_CYC  = 1024,
  parameter int unsigned PLL_CYC  = 2048,
  parameter int unsigned STAB_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] mode,
  input  logic       pri_running,
  input  logic       osc_pulse,
  output logic       osc_done,
  output logic       run_ok
);
  localparam int unsigned MAXC = (OST_CYC > PLL_CYC)
                               ? ((OST_CYC > STAB_CYC) ? OST_CYC : STAB_CYC)
                               : ((PLL_CYC > STAB_CYC) ? PLL_CYC : STAB_CYC);
  localparam int unsigned CW = $clog2(MAXC + 1);

  osc_stage_e    stage_q;
  logic          pll_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_DONE;
      pll_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (start) begin
      pll_q <= (mode == MODE_XTAL_PLL);
      if (pri_running || mode == MODE_EXT) begin
        stage_q <= ST_DONE;
        cnt_q   <= '0;
      end else if (mode == MODE_LFRC) begin
        stage_q <= ST_STAB;
        cnt_q   <= CW'(STAB_CYC);
      end else begin
        stage_q <= ST_OST;
        cnt_q   <= CW'(OST_CYC);
      end
    end else begin
      unique case (stage_q)
        ST_OST: if (osc_pulse) begin
          if (cnt_q == CW'(1)) begin
            stage_q <= pll_q ? ST_PLL : ST_DONE;
            cnt_q   <= pll_q ? CW'(PLL_CYC) : '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_PLL, ST_STAB: begin
          if (cnt_q == CW'(1)) begin
            stage_q <= ST_DONE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  assign osc_done = (stage_q == ST_DONE);
  assign run_ok   = (stage_q == ST_DONE) || (stage_q == ST_STAB);

  // R6
  ost_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && stage_q == ST_OST && !osc_pulse) |=> (stage_q == ST_OST && $stable(cnt_q)));

  // R7
  pll_after_ost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && stage_q == ST_PLL) |=> (stage_q == ST_PLL || stage_q == ST_DONE));
endmodule

// File: rtl/wake_exit_seq.sv
module wake_exit_seq
  import wake_exit_pkg::*;
#(
  parameter int unsigned OST_CYC  = 1024,
  parameter int unsigned PLL_CYC  = 2048,
  parameter int unsigned PREP_CYC = 16,
  parameter int unsigned STAB_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] clk_mode,
  input  logic       pri_running,
  input  logic       osc_pulse,
  input  logic       sleep_enter,
  input  logic       wake,
  output logic       cpu_run,
  output logic       clk_ready
);
  logic active_q, run_q, ready_q;
  logic start, prep_zero, osc_done, run_ok, sleep_go;

  assign start    = wake && !active_q && !run_q;
  assign sleep_go = sleep_enter && run_q && !active_q;

  prep_timer #(.PREP_CYC(PREP_CYC)) u_prep (
    .clk(clk), .rst_n(rst_n), .start(start), .zero(prep_zero)
  );

  osc_stage_ctrl #(.OST_CYC(OST_CYC), .PLL_CYC(PLL_CYC), .STAB_CYC(STAB_CYC)) u_osc (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(clk_mode),
    .pri_running(pri_running), .osc_pulse(osc_pulse),
    .osc_done(osc_done), .run_ok(run_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      run_q    <= 1'b1;
      ready_q  <= 1'b1;
    end else if (sleep_go) begin
      run_q <= 1'b0;
      if (!pri_running) ready_q <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
    end else if (active_q) begin
      if (prep_zero && run_ok) run_q   <= 1'b1;
      if (osc_done)            ready_q <= 1'b1;
      if (prep_zero && osc_done) active_q <= 1'b0;
    end
  end

  assign cpu_run   = run_q;
  assign clk_ready = ready_q;

  // R3
  prep_before_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(prep_zero));

  // R2
  sleep_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_go |=> !run_q);

  // R2
  ready_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_go && pri_running && ready_q) |=> ready_q);

  // R6
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(osc_done && active_q));

  // R9
  wake_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && wake) |-> !start);
endmodule

// File: tb/test_wake_exit_seq.sv
module test_wake_exit_seq;
  localparam int OST = 5, PLL = 7, PREP = 6, STAB = 9;

  logic clk = 0, rst_n = 0;
  logic [1:0] clk_mode = 0;
  logic pri_running = 0, osc_pulse = 0, sleep_enter = 0, wake = 0;
  logic cpu_run, clk_ready;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wake_exit_seq #(.OST_CYC(OST), .PLL_CYC(PLL), .PREP_CYC(PREP), .STAB_CYC(STAB)) i_wake_exit_seq (
    .clk(clk), .rst_n(rst_n), .clk_mode(clk_mode), .pri_running(pri_running),
    .osc_pulse(osc_pulse), .sleep_enter(sleep_enter), .wake(wake),
    .cpu_run(cpu_run), .clk_ready(clk_ready)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic run_case(int mode, bit pri, int d, bit inject);
    int first_run = -1, first_rdy = -1, exp_run, exp_rdy, e;
    string tag;
    @(negedge clk);
    clk_mode = 2'(mode); pri_running = pri; sleep_enter = 1;
    @(posedge clk); #1;
    sleep_enter = 0;
    check("R2 run drops", int'(cpu_run), 0);
    check("R2 ready after sleep", int'(clk_ready), int'(pri));
    @(negedge clk); wake = 1; osc_pulse = 0;
    @(posedge clk); #1;
    wake = 0;
    for (int k = 1; k <= 120; k++) begin
      @(negedge clk);
      osc_pulse = (k % d == 0);
      wake = inject && (k == 4);
      @(posedge clk); #1;
      wake = 0;
      if (cpu_run && first_run < 0) first_run = k;
      if (clk_ready && first_rdy < 0) first_rdy = k;
    end
    osc_pulse = 0;
    e = OST * d;
    if (pri) begin
      exp_run = PREP + 1; exp_rdy = 1; tag = "R4";
    end else if (mode == 0) begin
      exp_run = imax(e, PREP) + 1; exp_rdy = e + 1; tag = "R6";
    end else if (mode == 1) begin
      exp_run = imax(e + PLL, PREP) + 1; exp_rdy = e + PLL + 1; tag = "R7";
    end else if (mode == 2) begin
      exp_run = PREP + 1; exp_rdy = 1; tag = "R5";
    end else begin
      exp_run = PREP + 1; exp_rdy = STAB + 1; tag = "R8";
    end
    if (inject) tag = "R9";
    check({tag, " run edge"}, first_run, exp_run);
    check({tag, " ready edge"}, first_rdy, exp_rdy);
    // R3: never before preparation ends
    check("R3 prep floor", int'(first_run >= PREP + 1), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset run", int'(cpu_run), 1);
    check("R1 reset ready", int'(clk_ready), 1);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1 run after release", int'(cpu_run), 1);
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 2; p++)
        for (int d = 1; d <= 3; d++)
          run_case(m, p[0], d, 1'b0);
    run_case(0, 1'b0, 2, 1'b1);
    run_case(1, 1'b0, 1, 1'b1);
    run_case(3, 1'b0, 1, 1'b1);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule